// File: doc/BRIEF.md
# Sixteen-Pin GPIO Bank with Interrupt Detection

This block is one bank of general-purpose pins behind a word-indexed register interface. Software picks, per pin, whether it drives or listens, what value it drives, and whether the driven value comes from the bank's own output register or from an alternate-function source elsewhere on the chip. Two low-power conditions, sleep and battery fault, substitute stored output values so the pads settle into a safe state without software acting.

Every pin also has an event detector. The detector looks at the synchronized pin state and watches for either a level or an edge, with a programmable polarity. Detected events are latched into a status register that software clears by writing ones. A single interrupt line is the OR of the latched bits that are not masked. While sleep is active, a separate mask register applies.

The register bus carries a word index: the index is the byte offset divided by four. A write takes effect on the clock edge where `wr_en` is high. Read data is registered and appears one cycle after the index is presented.

Top module: `gpio_bank`

## Requirements
- R1: Synchronous active-high reset clears every register. It drives `pin_out`, `pin_oe`, `irq` and `rdata` to zero.
- R2: Word indices have these meanings:
  - 0: interrupt mask
  - 1: direction
  - 2: output value
  - 3: trigger kind
  - 4: edge polarity
  - 5: level polarity
  - 6: sleep mask
  - 7: sleep output
  - 8: battery-fault output
  - 9: status
  - 10: alternate select
  - 11: sleep config
  - 12: pin state

  Indices 0–8 and 10 read back what was written. Index 11 stores only bit 1, and its other bits read 0. Writes to index 12 are ignored. Indices 13–15 read 0. `rdata` shows the register selected by `addr` one clock after the index is presented.
- R3: `pin_oe` follows the direction register (1 = output, 0 = input) one clock after the register changes. When no override applies, `pin_out` follows the output-value register, where 0 drives low.
- R4: A pin whose alternate-select bit is 1 drives `alt_data` for that pin instead of the output-value register.
- R5: While `sleep_mode` is high, or while sleep-config bit 1 (autosleep) is set, `pin_out` takes the sleep-output register. This overrides both the alternate select and the output-value register. With autosleep 0, the sleep values apply only while `sleep_mode` is high.
- R6: While `batt_fault` is high, `pin_out` takes the battery-fault-output register. This overrides every other source, sleep included.
- R7: `pin_in` passes through two flip-flops before any other use. Index 12 reads the synchronized value, so a pin change is visible in `rdata` on the third clock after it.
- R8: With trigger-kind bit 1 (edge), a synchronized rising edge sets the status bit when the edge-polarity bit is 1. A falling edge sets it when the edge-polarity bit is 0.
- R9: With trigger-kind bit 0 (level), the status bit is set when the synchronized pin is high and the level-polarity bit is 1, or when it is low and that bit is 0. The bit is set again on every clock while the level persists.
- R10: Writing to index 9 clears each status bit written as 1. Bits written as 0 are unchanged. An event detected on the same clock as the clear leaves the bit set.
- R11: `irq` is the registered OR of status bits whose mask bit is 0. The mask is the interrupt-mask register while `sleep_mode` is low, and the sleep-mask register while it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register word index (byte offset / 4) |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Registered read data |
| pin_in | input | 16 | Pad input levels, asynchronous |
| pin_out | output | 16 | Pad output values |
| pin_oe | output | 16 | Pad output enables, 1 = drive |
| alt_data | input | 16 | Output data from alternate-function logic |
| sleep_mode | input | 1 | Sleep state active |
| batt_fault | input | 1 | Battery-fault state active |
| irq | output | 1 | Combined interrupt |

## Verification
The assertions take for granted that the bus, `sleep_mode`, `batt_fault` and `alt_data` are synchronous to `clk`, and that `addr` is a word index and not a byte offset. Only `pin_in` may change at any time, because the synchronizer absorbs it. The bench changes all inputs on the falling clock edge, so every rising edge sees stable values. It holds `pin_in` for several cycles when an exact edge or level event count matters. Random stretches mix writes at every index with pin toggles and mode changes, while the model tracks the resulting events cycle by cycle.

// File: rtl/gpio_pkg.sv
`timescale 1ns/1ps
package gpio_pkg;
  localparam int REG_IDX_W     = 4;
  localparam int AUTOSLEEP_BIT = 1;

  typedef enum logic [REG_IDX_W-1:0] {
    IDX_MASK  = 4'd0,
    IDX_DIR   = 4'd1,
    IDX_OUT   = 4'd2,
    IDX_TRIG  = 4'd3,
    IDX_EDGE  = 4'd4,
    IDX_LEVEL = 4'd5,
    IDX_SMASK = 4'd6,
    IDX_SOUT  = 4'd7,
    IDX_BFOUT = 4'd8,
    IDX_STAT  = 4'd9,
    IDX_ALT   = 4'd10,
    IDX_SCFG  = 4'd11,
    IDX_PIN   = 4'd12
  } reg_idx_e;
endpackage

// File: rtl/gpio_sync.sv
`timescale 1ns/1ps
module gpio_sync #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);
  logic [W-1:0] stage1_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1_q <= '0;
      sync_out <= '0;
    end else begin
      stage1_q <= async_in;
      sync_out <= stage1_q;
    end
  end
endmodule

// File: rtl/gpio_irq_detect.sv
`timescale 1ns/1ps
module gpio_irq_detect #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] pin_s,
  input  logic [W-1:0] edge_mode,
  input  logic [W-1:0] edge_rise,
  input  logic [W-1:0] level_high,
  input  logic [W-1:0] clr,
  output logic [W-1:0] status
);
  logic [W-1:0] prev_q;
  logic [W-1:0] hit;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= pin_s;
  end

  for (genvar i = 0; i < W; i++) begin : g_pin
    always_comb begin
      if (edge_mode[i])
        hit[i] = edge_rise[i] ? (pin_s[i] & ~prev_q[i]) : (~pin_s[i] & prev_q[i]);
      else
        hit[i] = level_high[i] ? pin_s[i] : ~pin_s[i];
    end

    always_ff @(posedge clk) begin
      if (rst) status[i] <= 1'b0;
      else     status[i] <= (status[i] & ~clr[i]) | hit[i];
    end
  end
endmodule

// File: rtl/gpio_out_mux.sv
`timescale 1ns/1ps
module gpio_out_mux #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] dir,
  input  logic [W-1:0] out_val,
  input  logic [W-1:0] alt_sel,
  input  logic [W-1:0] alt_data,
  input  logic [W-1:0] sleep_val,
  input  logic [W-1:0] fault_val,
  input  logic         sleep_on,
  input  logic         fault_on,
  output logic [W-1:0] pin_out,
  output logic [W-1:0] pin_oe
);
  logic [W-1:0] normal_val;
  logic [W-1:0] nxt;

  always_comb begin
    normal_val = (alt_sel & alt_data) | (~alt_sel & out_val);
    if (fault_on)      nxt = fault_val;
    else if (sleep_on) nxt = sleep_val;
    else               nxt = normal_val;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_out <= '0;
      pin_oe  <= '0;
    end else begin
      pin_out <= nxt;
      pin_oe  <= dir;
    end
  end
endmodule

// File: rtl/gpio_bank.sv
`timescale 1ns/1ps
module gpio_bank
  import gpio_pkg::*;
#(
  parameter int NPINS = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [REG_IDX_W-1:0] addr,
  input  logic [NPINS-1:0]     wdata,
  output logic [NPINS-1:0]     rdata,
  input  logic [NPINS-1:0]     pin_in,
  output logic [NPINS-1:0]     pin_out,
  output logic [NPINS-1:0]     pin_oe,
  input  logic [NPINS-1:0]     alt_data,
  input  logic                 sleep_mode,
  input  logic                 batt_fault,
  output logic                 irq
);
  logic [NPINS-1:0] mask_q, dir_q, out_q, trig_q, edge_q, lvl_q;
  logic [NPINS-1:0] smask_q, sout_q, bf_q, alt_q;
  logic             autoslp_q;
  logic [NPINS-1:0] sync_q, status_q, clr, eff_mask, scfg_rd;

  gpio_sync #(.W(NPINS)) u_sync (
    .clk(clk), .rst(rst), .async_in(pin_in), .sync_out(sync_q)
  );

  assign clr = (wr_en && addr == IDX_STAT) ? wdata : '0;

  gpio_irq_detect #(.W(NPINS)) u_det (
    .clk(clk), .rst(rst), .pin_s(sync_q), .edge_mode(trig_q),
    .edge_rise(edge_q), .level_high(lvl_q), .clr(clr), .status(status_q)
  );

  gpio_out_mux #(.W(NPINS)) u_mux (
    .clk(clk), .rst(rst), .dir(dir_q), .out_val(out_q), .alt_sel(alt_q),
    .alt_data(alt_data), .sleep_val(sout_q), .fault_val(bf_q),
    .sleep_on(sleep_mode | autoslp_q), .fault_on(batt_fault),
    .pin_out(pin_out), .pin_oe(pin_oe)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0; dir_q <= '0; out_q <= '0; trig_q <= '0; edge_q <= '0;
      lvl_q <= '0; smask_q <= '0; sout_q <= '0; bf_q <= '0; alt_q <= '0;
      autoslp_q <= 1'b0;
    end else if (wr_en) begin
      case (addr)
        IDX_MASK:  mask_q    <= wdata;
        IDX_DIR:   dir_q     <= wdata;
        IDX_OUT:   out_q     <= wdata;
        IDX_TRIG:  trig_q    <= wdata;
        IDX_EDGE:  edge_q    <= wdata;
        IDX_LEVEL: lvl_q     <= wdata;
        IDX_SMASK: smask_q   <= wdata;
        IDX_SOUT:  sout_q    <= wdata;
        IDX_BFOUT: bf_q      <= wdata;
        IDX_ALT:   alt_q     <= wdata;
        IDX_SCFG:  autoslp_q <= wdata[AUTOSLEEP_BIT];
        default: ;
      endcase
    end
  end

  always_comb begin
    scfg_rd = '0;
    scfg_rd[AUTOSLEEP_BIT] = autoslp_q;
    eff_mask = sleep_mode ? smask_q : mask_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
      irq   <= 1'b0;
    end else begin
      irq <= |(status_q & ~eff_mask);
      case (addr)
        IDX_MASK:  rdata <= mask_q;
        IDX_DIR:   rdata <= dir_q;
        IDX_OUT:   rdata <= out_q;
        IDX_TRIG:  rdata <= trig_q;
        IDX_EDGE:  rdata <= edge_q;
        IDX_LEVEL: rdata <= lvl_q;
        IDX_SMASK: rdata <= smask_q;
        IDX_SOUT:  rdata <= sout_q;
        IDX_BFOUT: rdata <= bf_q;
        IDX_STAT:  rdata <= status_q;
        IDX_ALT:   rdata <= alt_q;
        IDX_SCFG:  rdata <= scfg_rd;
        IDX_PIN:   rdata <= sync_q;
        default:   rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/gpio_bank_chk.sv
`timescale 1ns/1ps
module gpio_bank_chk
  import gpio_pkg::*;
#(
  parameter int NPINS = 16
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 wr_en,
  input logic [REG_IDX_W-1:0] addr,
  input logic [NPINS-1:0]     wdata,
  input logic [NPINS-1:0]     pin_in,
  input logic [NPINS-1:0]     pin_out,
  input logic [NPINS-1:0]     pin_oe,
  input logic                 sleep_mode,
  input logic                 batt_fault,
  input logic                 irq,
  input logic [NPINS-1:0]     sync_q,
  input logic [NPINS-1:0]     status_q,
  input logic [NPINS-1:0]     mask_q,
  input logic [NPINS-1:0]     smask_q,
  input logic [NPINS-1:0]     bf_q
);
  assert_oe_tracks_dir_R3: assert property (@(posedge clk) disable iff (rst)
    ($past(wr_en, 2) && $past(addr, 2) == IDX_DIR && !$past(rst, 2) && !$past(rst))
      |-> pin_oe == $past(wdata, 2));

  assert_fault_wins_R6: assert property (@(posedge clk) disable iff (rst)
    batt_fault |=> pin_out == $past(bf_q));

  assert_sync_depth_R7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rst, 2)) |-> sync_q == $past(pin_in, 2));

  assert_clear_needs_write_R10: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !($past(wr_en) && $past(addr) == IDX_STAT))
      |-> ($past(status_q) & ~status_q) == '0);

  assert_quiet_irq_R11: assert property (@(posedge clk) disable iff (rst)
    ((status_q & ~(sleep_mode ? smask_q : mask_q)) == '0) |=> !irq);
endmodule

bind gpio_bank gpio_bank_chk #(.NPINS(NPINS)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
  .sleep_mode(sleep_mode), .batt_fault(batt_fault), .irq(irq),
  .sync_q(sync_q), .status_q(status_q), .mask_q(mask_q),
  .smask_q(smask_q), .bf_q(bf_q)
);

// File: tb/sim_gpio_bank.sv
`timescale 1ns/1ps
module sim_gpio_bank;
  import gpio_pkg::*;
  localparam int N  = 16;
  localparam int IW = REG_IDX_W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic          wr_en = 1'b0;
  logic [IW-1:0] addr = '0;
  logic [N-1:0]  wdata = '0, pin_in = '0, alt_data = '0;
  logic          sleep_mode = 1'b0, batt_fault = 1'b0;
  logic [N-1:0]  rdata, pin_out, pin_oe;
  logic          irq;

  gpio_bank #(.NPINS(N)) u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
    .alt_data(alt_data), .sleep_mode(sleep_mode), .batt_fault(batt_fault),
    .irq(irq)
  );

  int    n_chk = 0, n_fail = 0;
  string tag = "R1";
  bit    done = 1'b0;

  // behavioural reference model
  logic [N-1:0] m_reg [0:15];
  logic [N-1:0] m_stat, m_s1, m_s2, m_prev, m_rd, m_out, m_oe;
  logic [N-1:0] ev, clrv, emask;
  logic         m_irq;

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 16; i++) m_reg[i] = '0;
      m_stat = '0; m_s1 = '0; m_s2 = '0; m_prev = '0;
      m_rd = '0; m_out = '0; m_oe = '0; m_irq = 1'b0;
    end else begin
      for (int i = 0; i < N; i++) begin
        if (m_reg[3][i]) ev[i] = m_reg[4][i] ? (m_s2[i] && !m_prev[i]) : (!m_s2[i] && m_prev[i]);
        else             ev[i] = m_reg[5][i] ? m_s2[i] : !m_s2[i];
        if (batt_fault)                      m_out[i] = m_reg[8][i];
        else if (sleep_mode || m_reg[11][1]) m_out[i] = m_reg[7][i];
        else if (m_reg[10][i])               m_out[i] = alt_data[i];
        else                                 m_out[i] = m_reg[2][i];
      end
      clrv  = (wr_en && addr == 4'd9) ? wdata : '0;
      emask = sleep_mode ? m_reg[6] : m_reg[0];
      m_irq = (m_stat & ~emask) != '0;
      m_oe  = m_reg[1];
      if (addr == 4'd9)       m_rd = m_stat;
      else if (addr == 4'd12) m_rd = m_s2;
      else if (addr > 4'd12)  m_rd = '0;
      else                    m_rd = m_reg[addr];
      m_stat = (m_stat & ~clrv) | ev;
      if (wr_en) begin
        if (addr <= 4'd8 || addr == 4'd10) m_reg[addr] = wdata;
        else if (addr == 4'd11)            m_reg[11] = wdata & 16'h0002;
      end
      m_prev = m_s2; m_s2 = m_s1; m_s1 = pin_in;
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      bit bad;
      bad = 1'b0;
      n_chk++;
      if (pin_out !== m_out) begin $display("FAIL %s pin_out act=%h exp=%h", tag, pin_out, m_out); bad = 1'b1; end
      if (pin_oe  !== m_oe)  begin $display("FAIL %s pin_oe act=%h exp=%h", tag, pin_oe, m_oe); bad = 1'b1; end
      if (irq     !== m_irq) begin $display("FAIL %s irq act=%b exp=%b", tag, irq, m_irq); bad = 1'b1; end
      if (rdata   !== m_rd)  begin $display("FAIL %s rdata act=%h exp=%h", tag, rdata, m_rd); bad = 1'b1; end
      if (bad) n_fail++;
    end
  end

  task automatic expect_v(input string t, input string what, input logic [N-1:0] act, input logic [N-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s act=%h exp=%h", t, what, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [N-1:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a[IW-1:0]; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd_chk(input int a, input logic [N-1:0] exp, input string t);
    @(negedge clk); addr = a[IW-1:0];
    @(negedge clk); expect_v(t, "rdata", rdata, exp);
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; wr_en = 1'b0; addr = '0; wdata = '0; pin_in = '0;
    alt_data = '0; sleep_mode = 1'b0; batt_fault = 1'b0;
    wait_n(3);
    rst = 1'b0;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    // R1: reset state
    wait_n(4);
    rst = 1'b0;
    expect_v("R1", "pin_out", pin_out, '0);
    expect_v("R1", "pin_oe", pin_oe, '0);
    expect_v("R1", "irq", {15'd0, irq}, '0);
    expect_v("R1", "rdata", rdata, '0);

    // R2: register map readback
    tag = "R2";
    wr(0, 16'hFFFF);
    for (int i = 0; i <= 10; i++) if (i != 9) wr(i, 16'(i * 16'h1357 + 16'h0421));
    for (int i = 0; i <= 10; i++) if (i != 9) rd_chk(i, 16'(i * 16'h1357 + 16'h0421), "R2");
    wr(11, 16'hFFFF);
    rd_chk(11, 16'h0002, "R2");
    wr(12, 16'hFFFF);
    rd_chk(12, 16'h0000, "R2");
    rd_chk(14, 16'h0000, "R2");

    // R3: direction and output value
    do_reset(); tag = "R3";
    wr(1, 16'hFF00); wr(2, 16'h0F0F); wait_n(2);
    expect_v("R3", "pin_oe", pin_oe, 16'hFF00);
    expect_v("R3", "pin_out", pin_out, 16'h0F0F);

    // R4: alternate select
    tag = "R4";
    alt_data = 16'hAAAA; wr(10, 16'h00FF); wait_n(2);
    expect_v("R4", "pin_out", pin_out, 16'h0FAA);
    alt_data = 16'h5555; wait_n(2);
    expect_v("R4", "pin_out", pin_out, 16'h0F55);

    // R5: sleep values, by input and by autosleep
    tag = "R5";
    wr(7, 16'h1234); sleep_mode = 1'b1; wait_n(2);
    expect_v("R5", "pin_out sleep", pin_out, 16'h1234);
    sleep_mode = 1'b0; wait_n(2);
    expect_v("R5", "pin_out awake", pin_out, 16'h0F55);
    wr(11, 16'h0002); wait_n(2);
    expect_v("R5", "pin_out autosleep", pin_out, 16'h1234);
    wr(11, 16'h0000); wait_n(2);
    expect_v("R5", "pin_out no autosleep", pin_out, 16'h0F55);

    // R6: battery fault priority
    tag = "R6";
    wr(8, 16'hC3C3); sleep_mode = 1'b1; batt_fault = 1'b1; wait_n(2);
    expect_v("R6", "pin_out fault", pin_out, 16'hC3C3);
    batt_fault = 1'b0; wait_n(2);
    expect_v("R6", "pin_out fault off", pin_out, 16'h1234);
    sleep_mode = 1'b0;

    // R7: synchronizer depth seen through pin state
    tag = "R7";
    @(negedge clk); addr = 4'd12; pin_in = '0; wait_n(4);
    pin_in = 16'h5A5A;
    wait_n(2);
    expect_v("R7", "pin state early", rdata, 16'h0000);
    wait_n(1);
    expect_v("R7", "pin state", rdata, 16'h5A5A);

    // R8: edge detection, both polarities
    do_reset(); tag = "R8";
    wr(3, 16'hFFFF); wr(4, 16'h00FF); wr(9, 16'hFFFF); wait_n(2);
    wr(9, 16'hFFFF);
    rd_chk(9, 16'h0000, "R8");
    pin_in = 16'hFFFF; wait_n(5);
    rd_chk(9, 16'h00FF, "R8");
    wr(9, 16'hFFFF); pin_in = 16'h0000; wait_n(5);
    rd_chk(9, 16'hFF00, "R8");

    // R9: level detection
    do_reset(); tag = "R9";
    wait_n(3);
    rd_chk(9, 16'hFFFF, "R9");
    wr(5, 16'hFFFF); wr(9, 16'hFFFF);
    rd_chk(9, 16'h0000, "R9");

    // R10: write-one-to-clear and same-cycle event priority
    tag = "R10";
    pin_in = 16'hFFFF; wait_n(5);
    wr(9, 16'hFFFF);
    rd_chk(9, 16'hFFFF, "R10");
    wr(5, 16'h0000); wait_n(2);
    wr(9, 16'h0F0F);
    rd_chk(9, 16'hF0F0, "R10");
    wr(9, 16'h0000);
    rd_chk(9, 16'hF0F0, "R10");

    // R11: interrupt with normal and sleep masks
    do_reset(); tag = "R11";
    wait_n(3);
    expect_v("R11", "irq unmasked", {15'd0, irq}, 16'h0001);
    wr(0, 16'hFFFF); wait_n(2);
    expect_v("R11", "irq masked", {15'd0, irq}, 16'h0000);
    sleep_mode = 1'b1; wait_n(2);
    expect_v("R11", "irq sleep mask clear", {15'd0, irq}, 16'h0001);
    wr(6, 16'hFFFF); wait_n(2);
    expect_v("R11", "irq sleep masked", {15'd0, irq}, 16'h0000);
    sleep_mode = 1'b0;

    // mixed random traffic against the model
    do_reset(); tag = "R10";
    for (int c = 0; c < 4000; c++) begin
      @(negedge clk);
      wr_en      = ($urandom_range(0, 3) == 0);
      addr       = IW'($urandom_range(0, 15));
      wdata      = N'($urandom);
      if ($urandom_range(0, 3) == 0) pin_in = N'($urandom);
      alt_data   = N'($urandom);
      sleep_mode = ($urandom_range(0, 7) == 0);
      batt_fault = ($urandom_range(0, 15) == 0);
    end
    @(negedge clk); wr_en = 1'b0;
    wait_n(2);
    finish_run();
  end
endmodule